// File: doc/BRIEF.md
# RISC Integer Execute Unit

This block is the purely combinational arithmetic and logic stage of a 32-bit load/store RISC datapath. Each cycle the decoder presents an operation code, two register operands, the 16-bit immediate field and the 5-bit constant shift field. The unit returns a 32-bit result and a flag that is high when that result is zero. The flag feeds the equality test of conditional branches.

The unit extends the immediate differently for each operation. Add-immediate reads the immediate as a signed value. The bitwise immediate forms pad it with zeros. A separate upper-immediate path moves it into the top half of the word. There is no subtract-immediate operation: subtracting a constant is an add-immediate with a negative value. A full 32-bit constant is built from an upper-immediate followed by an OR-immediate. Shifts take their amount either from the instruction's shift field or from the low bits of a register operand.

Top module: `int_exec_unit`

## Requirements
- R1: Operation code 0 returns src_a + src_b and code 1 returns src_a - src_b, both wrapping modulo 2^32.
- R2: Codes 2, 3 and 4 return the bitwise AND, OR and XOR of src_a and src_b.
- R3: Code 5 returns the bitwise NOR of src_a and src_b, so a zero src_b yields the inverse of src_a.
- R4: Code 6 returns 1 when src_a is less than src_b as signed two's complement values and 0 otherwise, with bits 31:1 always 0.
- R5: Code 7 returns src_a plus the immediate sign-extended from bit 15, so a negative immediate subtracts a constant.
- R6: Codes 8, 9 and 10 return the AND, OR and XOR of src_a with the immediate zero-extended to 32 bits.
- R7: Code 11 returns the immediate in bits 31:16 and zeros in bits 15:0; an OR-immediate applied to that result fills bits 15:0.
- R8: Codes 12, 13 and 14 shift src_b left logically, right logically and right arithmetically by the shift field (0 to 31).
- R9: Codes 15, 16 and 17 perform the same three shifts of src_b by the amount in src_a[4:0], ignoring src_a[31:5] and the shift field.
- R10: The zero flag is high exactly when the 32-bit result equals zero.
- R11: Codes 18 to 31 return a zero result, and therefore a high zero flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 5 | Decoded operation code |
| src_a_i | input | 32 | First register operand; holds the amount for variable shifts |
| src_b_i | input | 32 | Second register operand; holds the shifted value for shifts |
| imm_i | input | 16 | Immediate field of the instruction |
| shamt_i | input | 5 | Constant shift field of the instruction |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | High when result_o is zero |

## Verification
The unit has no registers, so every result and the zero flag are due within the same cycle as the inputs that produce them. Zero cycles of latency apply to every operation code. The bench drives a new set of inputs on the rising edge of its clock and samples on the following falling edge. Any settling after an input change is therefore complete before the sample is taken. The upper-immediate and OR-immediate chain is checked as two such cycles, with the first result fed back as the operand of the second.

// File: rtl/int_exec_unit.sv
module int_exec_unit #(
  parameter int DW = 32,
  parameter int IW = 16
) (
  input  logic [4:0]            op_i,
  input  logic [DW-1:0]         src_a_i,
  input  logic [DW-1:0]         src_b_i,
  input  logic [IW-1:0]         imm_i,
  input  logic [$clog2(DW)-1:0] shamt_i,
  output logic [DW-1:0]         result_o,
  output logic                  zero_o
);
  localparam int SW = $clog2(DW);

  localparam logic [4:0] OP_ADD  = 5'd0;
  localparam logic [4:0] OP_SUB  = 5'd1;
  localparam logic [4:0] OP_AND  = 5'd2;
  localparam logic [4:0] OP_OR   = 5'd3;
  localparam logic [4:0] OP_XOR  = 5'd4;
  localparam logic [4:0] OP_NOR  = 5'd5;
  localparam logic [4:0] OP_SLT  = 5'd6;
  localparam logic [4:0] OP_ADDI = 5'd7;
  localparam logic [4:0] OP_ANDI = 5'd8;
  localparam logic [4:0] OP_ORI  = 5'd9;
  localparam logic [4:0] OP_XORI = 5'd10;
  localparam logic [4:0] OP_LUI  = 5'd11;
  localparam logic [4:0] OP_SLL  = 5'd12;
  localparam logic [4:0] OP_SRL  = 5'd13;
  localparam logic [4:0] OP_SRA  = 5'd14;
  localparam logic [4:0] OP_SLLV = 5'd15;
  localparam logic [4:0] OP_SRLV = 5'd16;
  localparam logic [4:0] OP_SRAV = 5'd17;

  logic [DW-1:0] imm_sx, imm_zx, imm_up;
  logic [SW-1:0] sh_amt;
  logic          var_sh;

  assign imm_sx = {{(DW-IW){imm_i[IW-1]}}, imm_i};
  assign imm_zx = {{(DW-IW){1'b0}}, imm_i};
  assign imm_up = {imm_i, {(DW-IW){1'b0}}};
  assign var_sh = (op_i == OP_SLLV) || (op_i == OP_SRLV) || (op_i == OP_SRAV);
  assign sh_amt = var_sh ? src_a_i[SW-1:0] : shamt_i;

  always_comb begin
    case (op_i)
      OP_ADD:           result_o = src_a_i + src_b_i;
      OP_SUB:           result_o = src_a_i - src_b_i;
      OP_AND:           result_o = src_a_i & src_b_i;
      OP_OR:            result_o = src_a_i | src_b_i;
      OP_XOR:           result_o = src_a_i ^ src_b_i;
      OP_NOR:           result_o = ~(src_a_i | src_b_i);
      OP_SLT:           result_o = {{(DW-1){1'b0}}, $signed(src_a_i) < $signed(src_b_i)};
      OP_ADDI:          result_o = src_a_i + imm_sx;
      OP_ANDI:          result_o = src_a_i & imm_zx;
      OP_ORI:           result_o = src_a_i | imm_zx;
      OP_XORI:          result_o = src_a_i ^ imm_zx;
      OP_LUI:           result_o = imm_up;
      OP_SLL, OP_SLLV:  result_o = src_b_i << sh_amt;
      OP_SRL, OP_SRLV:  result_o = src_b_i >> sh_amt;
      OP_SRA, OP_SRAV:  result_o = $signed(src_b_i) >>> sh_amt;
      default:          result_o = '0;
    endcase
  end

  assign zero_o = ~|result_o;
endmodule

// File: rtl/int_exec_unit_chk.sv
module int_exec_unit_chk #(
  parameter int DW = 32,
  parameter int IW = 16
) (
  input logic [4:0]            op_i,
  input logic [DW-1:0]         src_a_i,
  input logic [DW-1:0]         src_b_i,
  input logic [IW-1:0]         imm_i,
  input logic [$clog2(DW)-1:0] shamt_i,
  input logic [DW-1:0]         result_o,
  input logic                  zero_o
);
  localparam int SW = $clog2(DW);

  always_comb begin
    if (op_i == 5'd5 && src_b_i == '0)
      p_nor_is_not_r3: assert (result_o == ~src_a_i);
    if (op_i == 5'd6)
      p_slt_upper_clear_r4: assert (result_o[DW-1:1] == '0);
    if (op_i == 5'd9)
      p_ori_upper_kept_r6: assert (result_o[DW-1:IW] == src_a_i[DW-1:IW]);
    if (op_i == 5'd11)
      p_lui_low_clear_r7: assert (result_o[DW-IW-1:0] == '0 && result_o[DW-1:DW-IW] == imm_i);
    if (op_i == 5'd14)
      p_sra_sign_kept_r8: assert (result_o[DW-1] == src_b_i[DW-1]);
    if ((op_i == 5'd15 || op_i == 5'd16 || op_i == 5'd17) && src_a_i[SW-1:0] == '0)
      p_var_shift_zero_r9: assert (result_o == src_b_i);
    if (zero_o)
      p_zero_flag_r10: assert (result_o == '0);
    if (op_i > 5'd17)
      p_unused_code_r11: assert (zero_o);
  end
endmodule

bind int_exec_unit int_exec_unit_chk #(.DW(DW), .IW(IW)) u_chk (
  .op_i(op_i), .src_a_i(src_a_i), .src_b_i(src_b_i), .imm_i(imm_i),
  .shamt_i(shamt_i), .result_o(result_o), .zero_o(zero_o)
);

// File: tb/test_int_exec_unit.sv
`timescale 1ns/1ps
module test_int_exec_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [4:0]  op;
  logic [31:0] a, b, y;
  logic [15:0] imm;
  logic [4:0]  sh;
  logic        z;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  int_exec_unit i_int_exec_unit (
    .op_i(op), .src_a_i(a), .src_b_i(b), .imm_i(imm), .shamt_i(sh),
    .result_o(y), .zero_o(z)
  );

  function automatic string tag_of(input logic [4:0] o);
    case (o)
      0, 1: return "R1";
      2, 3, 4: return "R2";
      5: return "R3";
      6: return "R4";
      7: return "R5";
      8, 9, 10: return "R6";
      11: return "R7";
      12, 13, 14: return "R8";
      15, 16, 17: return "R9";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [31:0] shift_ref(input int kind, input logic [31:0] v, input int n);
    logic [31:0] x = v;
    for (int k = 0; k < n; k++) begin
      if (kind == 0) x = {x[30:0], 1'b0};
      else if (kind == 1) x = {1'b0, x[31:1]};
      else x = {x[31], x[31:1]};
    end
    return x;
  endfunction

  function automatic logic [31:0] model(input logic [4:0] o, input logic [31:0] ra, input logic [31:0] rb,
                                        input logic [15:0] im, input logic [4:0] s);
    logic [31:0] sx = im[15] ? (32'hFFFF0000 | im) : {16'h0, im};
    logic [31:0] zx = {16'h0, im};
    case (o)
      0: return ra + rb;
      1: return ra + ~rb + 32'd1;
      2: return ra & rb;
      3: return ra | rb;
      4: return ra ^ rb;
      5: return ~ra & ~rb;
      6: return ((ra ^ 32'h80000000) < (rb ^ 32'h80000000)) ? 32'd1 : 32'd0;
      7: return ra + sx;
      8: return ra & zx;
      9: return ra | zx;
      10: return ra ^ zx;
      11: return {16'h0, im} * 32'd65536;
      12: return shift_ref(0, rb, int'(s));
      13: return shift_ref(1, rb, int'(s));
      14: return shift_ref(2, rb, int'(s));
      15: return shift_ref(0, rb, int'(ra % 32));
      16: return shift_ref(1, rb, int'(ra % 32));
      17: return shift_ref(2, rb, int'(ra % 32));
      default: return 32'd0;
    endcase
  endfunction

  task automatic apply(input logic [4:0] o, input logic [31:0] ra, input logic [31:0] rb,
                       input logic [15:0] im, input logic [4:0] s);
    logic [31:0] e;
    @(posedge clk);
    op = o; a = ra; b = rb; imm = im; sh = s;
    e = model(o, ra, rb, im, s);
    @(negedge clk);
    n_run++;
    if (y !== e) begin
      n_fail++;
      $display("FAIL %s op=%0d result actual=%h expected=%h", tag_of(o), o, y, e);
    end
    n_run++;
    if (z !== (e == 32'd0)) begin
      n_fail++;
      $display("FAIL R10 op=%0d zero actual=%b expected=%b", o, z, (e == 32'd0));
    end
  endtask

  logic [31:0] pats [8];

  initial begin
    pats[0] = 32'h00000000; pats[1] = 32'hFFFFFFFF; pats[2] = 32'h7FFFFFFF;
    pats[3] = 32'h80000000; pats[4] = 32'h00000001; pats[5] = 32'hF234012F;
    pats[6] = 32'h000012BC; pats[7] = 32'hA5A58001;
    op = 5'd31; a = '0; b = '0; imm = '0; sh = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // reset/idle state: unused code gives zero result (R11)
    @(negedge clk);
    n_run++;
    if (y !== 32'd0 || z !== 1'b1) begin
      n_fail++;
      $display("FAIL R11 idle actual=%h/%b expected=00000000/1", y, z);
    end
    // sweep every code over operand pairs (R1..R11)
    for (int o = 0; o < 32; o++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          apply(5'(o), pats[i], pats[j], pats[(i + j) % 8][15:0], 5'(i * 5 + j));
    // full shift range, constant and variable (R8, R9)
    for (int s = 0; s < 32; s++) begin
      apply(5'd12, 32'h0, 32'h8000F00D, 16'h0, 5'(s));
      apply(5'd13, 32'h0, 32'h8000F00D, 16'h0, 5'(s));
      apply(5'd14, 32'h0, 32'h8000F00D, 16'h0, 5'(s));
      apply(5'd14, 32'h0, 32'h4000F00D, 16'h0, 5'(s));
      apply(5'd15, 32'hFFFFFFE0 | s, 32'h8000F00D, 16'h0, 5'd7);
      apply(5'd16, 32'hFFFFFFE0 | s, 32'h8000F00D, 16'h0, 5'd7);
      apply(5'd17, 32'hFFFFFFE0 | s, 32'h8000F00D, 16'h0, 5'd7);
    end
    // NOT via NOR with zero (R3)
    apply(5'd5, 32'h12345678, 32'h0, 16'h0, 5'd0);
    // subtract constant via negative immediate (R5): 100 + (-12)
    apply(5'd7, 32'd100, 32'h0, 16'hFFF4, 5'd0);
    // zero-extension of a high-bit immediate (R6)
    apply(5'd8, 32'hFFFFFFFF, 32'h0, 16'h8765, 5'd0);
    // signed compare corner (R4): -1 < 1
    apply(5'd6, 32'hFFFFFFFF, 32'd1, 16'h0, 5'd0);
    // build a full constant: upper then OR-immediate (R7)
    apply(5'd11, 32'h0, 32'h0, 16'hFEDC, 5'd0);
    apply(5'd9, y, 32'h0, 16'h8765, 5'd0);
    n_run++;
    if (y !== 32'hFEDC8765) begin
      n_fail++;
      $display("FAIL R7 constant actual=%h expected=FEDC8765", y);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule